// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block holds a 256-entry color lookup table of 24-bit RGB values. Software fills it the way a classic RAMDAC is filled. A write to the index register picks a starting entry. Bytes written to the color-map register then land in red, green and blue of that entry, in that order. After each complete triplet the index moves on by itself. The color-map register accepts a single byte or a 32-bit word, and a word is taken as four bytes in a row, high byte first. A word that starts part way through a triplet carries on into the next entry.

A separate pixel port turns an 8-bit pixel index into packed RGB. It can run while software rewrites the table. After every color-map write a one-cycle change pulse tells a downstream display to redraw in full. By default the lookup is combinational. A parameter adds an output register.

Top module: `clut_loader`

## Requirements
- R1: After reset every entry reads as zero on the pixel port, the next color-map byte goes to red of index 0, and `palette_changed` is low.
- R2: A write at offset 0x00 loads the index from bits 7:0 of `bus_wdata` and returns the phase to red.
- R3: A byte write at offset 0x04 (`bus_wide`=0, data in bits 7:0) stores the byte in the current phase of the current index; phases run red, green, blue.
- R4: When the blue byte is stored, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A word write at offset 0x04 (`bus_wide`=1) delivers bits 31:24, 23:16, 15:8 and 7:0 as four successive bytes, each advancing the phase; bytes past blue continue into the next index.
- R6: `bus_rdata` is zero at all times, so reads of the index and color-map offsets return zero.
- R7: `pix_rgb` is {red, green, blue} of the entry at `pix_idx`, in bits 23:16, 15:8 and 7:0, with no latency when PIX_REG is 0.
- R8: The pixel port works in the same cycle as a register write; an entry written at a clock edge shows its new value from that edge on, and shows the old value before it.
- R9: `palette_changed` is high for exactly the cycle after each color-map write and low otherwise.
- R10: Writes to any other offset change neither the table, the index nor the phase, and raise no change pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_wide | input | 1 | 1: four-byte write, 0: single byte in bits 7:0 |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Packed RGB of the looked-up entry |
| palette_changed | output | 1 | One-cycle pulse after a color-map write |

## Verification
Directed sequences start byte and word writes from each of the three phases and at index 255. They separate a correct wrap and a correct triplet crossing from an off-by-one in the phase or index arithmetic. A random mix of index loads, byte writes, word writes and writes to other offsets is compared against a bench model of the table. This tells byte order within a word apart from phase order within an entry. A lookup held on the entry being written shows whether the new value appears at the write edge and not earlier or later. A closing sweep of all entries catches writes that landed on the wrong index.

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int IDX_W = 8,
  parameter int COL_W = 8,
  parameter int AW = 5,
  parameter bit PIX_REG = 1'b0,
  parameter logic [AW-1:0] IDX_OFS = 5'h00,
  parameter logic [AW-1:0] CMAP_OFS = 5'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [4*COL_W-1:0] bus_wdata,
  input  logic               bus_wide,
  output logic [4*COL_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic [3*COL_W-1:0] pix_rgb,
  output logic               palette_changed
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int DW = 4 * COL_W;
  localparam logic [1:0] PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2;

  logic [COL_W-1:0] red_q [ENTRIES];
  logic [COL_W-1:0] grn_q [ENTRIES];
  logic [COL_W-1:0] blu_q [ENTRIES];
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       ph_q;
  logic             chg_q;

  wire idx_wr  = bus_wr && (bus_addr == IDX_OFS);
  wire cmap_wr = bus_wr && (bus_addr == CMAP_OFS);

  logic [COL_W-1:0] slot_byte [4];
  logic [1:0]       slot_ph   [4];
  logic [IDX_W-1:0] slot_idx  [4];
  logic             slot_en   [4];

  for (genvar k = 0; k < 4; k++) begin : g_slot
    wire [2:0] sum = {1'b0, ph_q} + 3'(k);
    assign slot_ph[k]  = (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
    assign slot_idx[k] = idx_q + IDX_W'(sum >= 3'd3);
    assign slot_en[k]  = cmap_wr && (bus_wide || k == 0);
    if (k == 0) begin : g_first
      assign slot_byte[k] = bus_wide ? bus_wdata[DW-1 -: COL_W] : bus_wdata[COL_W-1:0];
    end else begin : g_rest
      assign slot_byte[k] = bus_wdata[DW-1-k*COL_W -: COL_W];
    end
  end

  wire [2:0] tot = {1'b0, ph_q} + (bus_wide ? 3'd4 : 3'd1);
  wire [1:0] nxt_ph = (tot >= 3'd6) ? 2'd0 : (tot >= 3'd3) ? 2'(tot - 3'd3) : tot[1:0];
  wire [IDX_W-1:0] nxt_adv = (tot >= 3'd6) ? IDX_W'(2) : (tot >= 3'd3) ? IDX_W'(1) : IDX_W'(0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_R;
      chg_q <= 1'b0;
    end else begin
      chg_q <= cmap_wr;
      if (idx_wr) begin
        idx_q <= bus_wdata[IDX_W-1:0];
        ph_q  <= PH_R;
      end else if (cmap_wr) begin
        idx_q <= idx_q + nxt_adv;
        ph_q  <= nxt_ph;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red_q[i] <= '0;
        grn_q[i] <= '0;
        blu_q[i] <= '0;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (slot_en[k]) begin
          case (slot_ph[k])
            PH_R:    red_q[slot_idx[k]] <= slot_byte[k];
            PH_G:    grn_q[slot_idx[k]] <= slot_byte[k];
            default: blu_q[slot_idx[k]] <= slot_byte[k];
          endcase
        end
      end
    end
  end

  wire [3*COL_W-1:0] look = {red_q[pix_idx], grn_q[pix_idx], blu_q[pix_idx]};

  if (PIX_REG) begin : g_pix_reg
    logic [3*COL_W-1:0] rgb_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rgb_q <= '0;
      else        rgb_q <= look;
    end
    assign pix_rgb = rgb_q;
  end else begin : g_pix_comb
    assign pix_rgb = look;
  end

  assign bus_rdata = '0;
  assign palette_changed = chg_q;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int IDX_W = 8,
  parameter int COL_W = 8,
  parameter int AW = 5,
  parameter logic [AW-1:0] IDX_OFS = 5'h00,
  parameter logic [AW-1:0] CMAP_OFS = 5'h04
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [4*COL_W-1:0] bus_wdata,
  input logic               bus_wide,
  input logic               palette_changed,
  input logic [IDX_W-1:0]   idx,
  input logic [1:0]         ph
);
  wire a_idx  = bus_wr && bus_addr == IDX_OFS;
  wire a_cmap = bus_wr && bus_addr == CMAP_OFS;
  wire a_none = bus_wr && bus_addr != IDX_OFS && bus_addr != CMAP_OFS;

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_idx |=> (idx == $past(bus_wdata[IDX_W-1:0]) && ph == 2'd0));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmap && !bus_wide && ph != 2'd2) |=> (ph == $past(ph) + 2'd1 && idx == $past(idx)));

  assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmap && !bus_wide && ph == 2'd2) |=> (ph == 2'd0 && idx == $past(idx) + IDX_W'(1)));

  assert_word_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmap && bus_wide) |=> (idx == $past(idx) + (($past(ph) == 2'd2) ? IDX_W'(2) : IDX_W'(1))
                              && ph == (($past(ph) == 2'd2) ? 2'd0 : $past(ph) + 2'd1)));

  assert_change_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_cmap |=> palette_changed);

  assert_change_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !a_cmap |=> !palette_changed);

  assert_other_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_none |=> ($stable(idx) && $stable(ph)));
endmodule

bind clut_loader clut_loader_chk #(
  .IDX_W(IDX_W), .COL_W(COL_W), .AW(AW), .IDX_OFS(IDX_OFS), .CMAP_OFS(CMAP_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wide(bus_wide), .palette_changed(palette_changed),
  .idx(idx_q), .ph(ph_q)
);

// File: tb/sim_clut_loader.sv
module sim_clut_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wide = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        palette_changed;

  int checks = 0;
  int fails = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] midx;
  int         mph;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wide(bus_wide), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .palette_changed(palette_changed)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_rgb(logic [7:0] i);
    return {mr[i], mg[i], mb[i]};
  endfunction

  task automatic model_byte(logic [7:0] b);
    case (mph)
      0: mr[midx] = b;
      1: mg[midx] = b;
      default: mb[midx] = b;
    endcase
    mph++;
    if (mph == 3) begin
      mph = 0;
      midx = midx + 8'd1;
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [31:0] d, logic w, string req);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 5'h00) begin
      midx = d[7:0]; mph = 0;
    end else if (a == 5'h04) begin
      if (w) begin
        for (int k = 3; k >= 0; k--) model_byte(d[k*8 +: 8]);
      end else model_byte(d[7:0]);
    end
    check({req, " R9 change pulse"}, 32'(palette_changed), 32'(a == 5'h04));
  endtask

  task automatic look(logic [7:0] i, string req);
    pix_idx = i;
    #1;
    check(req, 32'(pix_rgb), 32'(model_rgb(i)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mr[i] = '0; mg[i] = '0; mb[i] = '0;
    end
    midx = '0; mph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    look(8'd0, "R1 entry 0 cleared");
    look(8'd255, "R1 entry 255 cleared");
    look(8'd77, "R1 entry 77 cleared");
    check("R1 change pulse low", 32'(palette_changed), 32'd0);
    do_write(5'h04, 32'h0000_005A, 1'b0, "R1");
    look(8'd0, "R1 first byte to red of index 0");

    // R6 read data
    check("R6 read data zero", bus_rdata, 32'd0);

    // R2/R3/R4 triplet at 255 and wrap
    do_write(5'h00, 32'hFFFF_FFFF, 1'b0, "R2");
    do_write(5'h04, 32'h0000_0011, 1'b0, "R3");
    do_write(5'h04, 32'h0000_0022, 1'b0, "R3");
    do_write(5'h04, 32'h0000_0033, 1'b0, "R4");
    look(8'd255, "R7 packing of entry 255");
    check("R7 explicit pack", 32'(pix_rgb), 32'h0011_2233);
    do_write(5'h04, 32'h0000_0044, 1'b0, "R4");
    look(8'd0, "R4 wrap to index 0");

    // R5 word starting at green
    do_write(5'h00, 32'h0000_000A, 1'b0, "R2");
    do_write(5'h04, 32'h0000_0001, 1'b0, "R3");
    do_write(5'h04, 32'hAABB_CCDD, 1'b1, "R5");
    look(8'd10, "R5 word completes index 10");
    check("R5 index 10 bytes", 32'(pix_rgb), 32'h0001_AABB);
    do_write(5'h04, 32'h0000_00EE, 1'b0, "R5");
    look(8'd11, "R5 word spills into index 11");
    check("R5 index 11 bytes", 32'(pix_rgb), 32'h00CC_DDEE);

    // R5 word starting at blue
    do_write(5'h00, 32'h0000_0020, 1'b0, "R2");
    do_write(5'h04, 32'h0000_0001, 1'b0, "R3");
    do_write(5'h04, 32'h0000_0002, 1'b0, "R3");
    do_write(5'h04, 32'h1122_3344, 1'b1, "R5");
    look(8'd32, "R5 blue start index 32");
    look(8'd33, "R5 blue start index 33");
    do_write(5'h04, 32'h0000_0099, 1'b0, "R5");
    look(8'd34, "R5 blue start lands on index 34");

    // R8 concurrent lookup on the entry being written
    do_write(5'h00, 32'h0000_0005, 1'b0, "R2");
    pix_idx = 8'd5;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h0000_00C3; bus_wide = 1'b0;
    #1;
    check("R8 old value before edge", 32'(pix_rgb), 32'(model_rgb(8'd5)));
    @(negedge clk);
    bus_wr = 1'b0;
    model_byte(8'hC3);
    check("R8 new value after edge", 32'(pix_rgb), 32'(model_rgb(8'd5)));
    @(negedge clk);
    check("R9 pulse lasts one cycle", 32'(palette_changed), 32'd0);

    // R10 other offsets ignored
    do_write(5'h10, 32'hDEAD_BEEF, 1'b1, "R10");
    do_write(5'h08, 32'h0000_0077, 1'b0, "R10");
    look(8'd5, "R10 table unchanged");
    do_write(5'h04, 32'h0000_0066, 1'b0, "R10");
    look(8'd5, "R10 phase kept after ignored writes");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom;
      if (op == 0) do_write(5'h00, d, 1'b0, "R2");
      else if (op <= 4) do_write(5'h04, d, 1'b0, "R3");
      else if (op <= 7) do_write(5'h04, d, 1'b1, "R5");
      else do_write(5'(($urandom_range(2, 7)) * 4), d, d[0], "R10");
      look(8'($urandom), "R7 random lookup");
      check("R6 read data zero", bus_rdata, 32'd0);
    end

    // sweep
    for (int i = 0; i < 256; i++) look(8'(i), "R8 final sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule